// File: doc/BRIEF.md
# Clock-Hand Page Frame Victim Selector

This block chooses which page frame to give up when a new page has to be brought into memory. It keeps one reference flag and one dirty flag for each frame of a small table, and a circular hand that points at the next frame to examine. Every access to a frame strobes the mark port, which sets that frame's reference flag. An access that writes also sets its dirty flag.

When the requester asks for a victim, a state machine sweeps forward from the hand, one frame per cycle. In the sweep it clears the reference flags it finds set and stops on the first frame whose flag was already clear. It then pulses a grant carrying the frame index and whether that frame holds modified data, so the requester knows a write-back is needed first. An optional clean-first mode runs a non-clearing pass before the sweep. That pass accepts only frames that are both unreferenced and clean.

The states are ST_IDLE (waiting), ST_SEEK_CLEAN (non-clearing pass that looks for a clean, unreferenced frame), ST_SWEEP (clearing pass that takes any unreferenced frame) and ST_GRANT (one-cycle grant). The transitions are named as follows. `start_plain`: ST_IDLE to ST_SWEEP on a request in basic mode. `start_clean`: ST_IDLE to ST_SEEK_CLEAN on a request in clean-first mode. `seek_hit`: ST_SEEK_CLEAN to ST_GRANT when a clean, unreferenced frame is found. `seek_exhausted`: ST_SEEK_CLEAN to ST_SWEEP after a full table without success. `sweep_hit`: ST_SWEEP to ST_GRANT. `grant_done`: ST_GRANT to ST_IDLE.

Top module: `nru_victim_picker`

## Requirements
- R1: A cycle with `mark_valid` high sets the reference flag of frame `mark_index`. If `mark_write` is also high, the dirty flag of that frame is set too.
- R2: In the clearing sweep, a frame whose reference flag is 1 when examined has the flag cleared and is passed over. The first examined frame whose flag is 0 becomes the victim.
- R3: A search starts at the hand and examines one frame per cycle in ascending index order. After frame N-1 it wraps to frame 0.
- R4: When `clean_first` is 1 in the cycle a request is accepted, a first pass of up to N frames accepts only a frame with reference 0 and dirty 0, and clears no flag. If that pass finds nothing, the clearing sweep of R2 follows from the same hand position. When `clean_first` is 0, the search is the sweep alone.
- R5: After a grant the hand points at the frame that follows the victim (modulo N), and the next search starts there.
- R6: A search examines at most 2N frames in basic mode and at most 3N frames in clean-first mode.
- R7: `req_valid` is sampled only while `busy` is low. `busy` is high from the next cycle until the grant. `gnt_valid` is high for exactly one cycle, and `busy` is low again in the cycle after it.
- R8: `gnt_dirty` reports the victim's dirty flag as it stood when the victim was chosen. The victim's dirty flag is then cleared, unless a write mark to that frame lands in the same cycle.
- R9: A mark to a frame in the same cycle that the sweep clears that frame's reference flag leaves the flag at 1.
- R10: Reset clears all reference and dirty flags, puts the hand at frame 0 and returns the machine to ST_IDLE with `busy` and `gnt_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_valid | input | 1 | Access strobe for one frame |
| mark_index | input | IDX_W | Frame being accessed |
| mark_write | input | 1 | Access is a write; also sets the dirty flag |
| req_valid | input | 1 | Victim request, sampled while idle |
| clean_first | input | 1 | Use the clean-preferring search for this request |
| busy | output | 1 | A search or grant is in progress |
| gnt_valid | output | 1 | One-cycle victim grant |
| gnt_index | output | IDX_W | Chosen frame, valid with `gnt_valid` |
| gnt_dirty | output | 1 | Chosen frame needs write-back |

## Verification
The bench builds the block with eight frames and the clean-first pass enabled. With eight frames, a short sequence of marks can push a search through a full wrap of the table. It can also carry the non-clearing pass to its last frame and on into the sweep. The cycle count of each search is measured at the ports. This separates a hand that resumes after the victim from one that does not, and separates a first pass that clears flags from one that leaves them. A mark timed to the exact cycle the sweep examines a frame exercises the set-over-clear priority, and the effect shows up in the choice of victim in the following search.

// File: rtl/nru_pkg.sv
package nru_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SEEK_CLEAN = 2'd1,
        ST_SWEEP      = 2'd2,
        ST_GRANT      = 2'd3
    } scan_state_t;

endpackage

// File: rtl/nru_flag_table.sv
module nru_flag_table #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mark_en,
    input  logic [IDX_W-1:0]     mark_idx,
    input  logic                 mark_wr,
    input  logic                 clr_ref_en,
    input  logic [IDX_W-1:0]     clr_ref_idx,
    input  logic                 clr_dirty_en,
    input  logic [IDX_W-1:0]     clr_dirty_idx,
    output logic [N_ENTRIES-1:0] ref_bits,
    output logic [N_ENTRIES-1:0] dirty_bits
);

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        logic hit_mark;
        logic hit_clr_ref;
        logic hit_clr_dirty;

        assign hit_mark      = mark_en && (mark_idx == IDX_W'(e));
        assign hit_clr_ref   = clr_ref_en && (clr_ref_idx == IDX_W'(e));
        assign hit_clr_dirty = clr_dirty_en && (clr_dirty_idx == IDX_W'(e));

        // set has priority over clear for both flags
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_bits[e] <= 1'b0;
            end else if (hit_mark) begin
                ref_bits[e] <= 1'b1;
            end else if (hit_clr_ref) begin
                ref_bits[e] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dirty_bits[e] <= 1'b0;
            end else if (hit_mark && mark_wr) begin
                dirty_bits[e] <= 1'b1;
            end else if (hit_clr_dirty) begin
                dirty_bits[e] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nru_clock_hand.sv
module nru_clock_hand #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] hand
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] hand_nxt;

    always_comb begin
        if (hand == LAST) begin
            hand_nxt = '0;
        end else begin
            hand_nxt = hand + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand <= '0;
        end else if (step) begin
            hand <= hand_nxt;
        end
    end

endmodule

// File: rtl/nru_scan_fsm.sv
module nru_scan_fsm
    import nru_pkg::*;
#(
    parameter int N_ENTRIES     = 8,
    parameter bit CLEAN_PASS_EN = 1'b1,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int CNT_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             clean_first,
    input  logic [IDX_W-1:0] hand,
    input  logic             cur_ref,
    input  logic             cur_dirty,
    output scan_state_t      state,
    output logic             step,
    output logic             clr_ref_en,
    output logic             clr_dirty_en,
    output logic [IDX_W-1:0] vict_idx,
    output logic             vict_dirty
);

    localparam logic [CNT_W-1:0] SEEK_LAST = CNT_W'(N_ENTRIES - 1);

    scan_state_t      state_nxt;
    logic             use_clean;
    logic             accept;
    logic [CNT_W-1:0] seek_cnt;

    // the clean-first pass exists only when the parameter enables it
    if (CLEAN_PASS_EN) begin : g_clean_pass
        assign use_clean = clean_first;
    end else begin : g_no_clean_pass
        assign use_clean = 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nxt = use_clean ? ST_SEEK_CLEAN : ST_SWEEP;
                end
            end
            ST_SEEK_CLEAN: begin
                if (accept) begin
                    state_nxt = ST_GRANT;
                end else if (seek_cnt == SEEK_LAST) begin
                    state_nxt = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (accept) begin
                    state_nxt = ST_GRANT;
                end
            end
            ST_GRANT: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        accept       = 1'b0;
        step         = 1'b0;
        clr_ref_en   = 1'b0;
        unique case (state)
            ST_SEEK_CLEAN: begin
                step   = 1'b1;
                accept = !cur_ref && !cur_dirty;
            end
            ST_SWEEP: begin
                step       = 1'b1;
                accept     = !cur_ref;
                clr_ref_en = cur_ref;
            end
            default: begin
            end
        endcase
        clr_dirty_en = accept;
    end

    // counts frames examined by the non-clearing pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seek_cnt <= '0;
        end else if (state == ST_SEEK_CLEAN) begin
            seek_cnt <= seek_cnt + 1'b1;
        end else begin
            seek_cnt <= '0;
        end
    end

    // victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vict_idx   <= '0;
            vict_dirty <= 1'b0;
        end else if (accept) begin
            vict_idx   <= hand;
            vict_dirty <= cur_dirty;
        end
    end

endmodule

// File: rtl/nru_victim_picker.sv
module nru_victim_picker
    import nru_pkg::*;
#(
    parameter int N_ENTRIES     = 8,
    parameter bit CLEAN_PASS_EN = 1'b1,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_valid,
    input  logic [IDX_W-1:0] mark_index,
    input  logic             mark_write,
    input  logic             req_valid,
    input  logic             clean_first,
    output logic             busy,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_index,
    output logic             gnt_dirty
);

    logic [N_ENTRIES-1:0] ref_bits;
    logic [N_ENTRIES-1:0] dirty_bits;
    logic [IDX_W-1:0]     hand;
    logic                 step;
    logic                 clr_ref_en;
    logic                 clr_dirty_en;
    logic                 cur_ref;
    logic                 cur_dirty;
    logic [IDX_W-1:0]     vict_idx;
    logic                 vict_dirty;
    scan_state_t          state;

    assign cur_ref   = ref_bits[hand];
    assign cur_dirty = dirty_bits[hand];

    nru_flag_table #(.N_ENTRIES(N_ENTRIES)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .mark_en       (mark_valid),
        .mark_idx      (mark_index),
        .mark_wr       (mark_write),
        .clr_ref_en    (clr_ref_en),
        .clr_ref_idx   (hand),
        .clr_dirty_en  (clr_dirty_en),
        .clr_dirty_idx (hand),
        .ref_bits      (ref_bits),
        .dirty_bits    (dirty_bits)
    );

    nru_clock_hand #(.N_ENTRIES(N_ENTRIES)) u_hand (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .hand  (hand)
    );

    nru_scan_fsm #(
        .N_ENTRIES     (N_ENTRIES),
        .CLEAN_PASS_EN (CLEAN_PASS_EN)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .clean_first  (clean_first),
        .hand         (hand),
        .cur_ref      (cur_ref),
        .cur_dirty    (cur_dirty),
        .state        (state),
        .step         (step),
        .clr_ref_en   (clr_ref_en),
        .clr_dirty_en (clr_dirty_en),
        .vict_idx     (vict_idx),
        .vict_dirty   (vict_dirty)
    );

    // port outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        gnt_valid = (state == ST_GRANT);
        gnt_index = vict_idx;
        gnt_dirty = vict_dirty;
    end

endmodule

// File: rtl/nru_victim_picker_chk.sv
module nru_victim_picker_chk #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int BND_W = $clog2(3 * N_ENTRIES + 4)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mark_valid,
    input logic [IDX_W-1:0]     mark_index,
    input logic                 busy,
    input logic                 gnt_valid,
    input logic [IDX_W-1:0]     gnt_index,
    input logic [IDX_W-1:0]     hand,
    input logic [N_ENTRIES-1:0] ref_bits
);

    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_ENTRIES - 1);
    localparam logic [BND_W-1:0] LIMIT = BND_W'(3 * N_ENTRIES + 1);

    logic [BND_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt <= '0;
        end else if (busy_cnt != LIMIT + 1'b1) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    p_mark_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid |=> ref_bits[$past(mark_index)]);

    p_victim_unref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !($past(mark_valid) && $past(mark_index) == gnt_index))
            |-> !ref_bits[gnt_index]);

    p_hand_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(hand));

    p_hand_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> hand == ((gnt_index == LAST) ? '0 : gnt_index + 1'b1));

    p_search_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt <= LIMIT);

    p_grant_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> (!gnt_valid && !busy));

endmodule

bind nru_victim_picker nru_victim_picker_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_valid (mark_valid),
    .mark_index (mark_index),
    .busy       (busy),
    .gnt_valid  (gnt_valid),
    .gnt_index  (gnt_index),
    .hand       (hand),
    .ref_bits   (ref_bits)
);

// File: tb/nru_victim_picker_test.sv
`timescale 1ns/1ps
module nru_victim_picker_test;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mark_valid = 1'b0;
    logic [IW-1:0] mark_index = '0;
    logic          mark_write = 1'b0;
    logic          req_valid = 1'b0;
    logic          clean_first = 1'b0;
    logic          busy;
    logic          gnt_valid;
    logic [IW-1:0] gnt_index;
    logic          gnt_dirty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    nru_victim_picker #(.N_ENTRIES(N), .CLEAN_PASS_EN(1'b1)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mark_valid  (mark_valid),
        .mark_index  (mark_index),
        .mark_write  (mark_write),
        .req_valid   (req_valid),
        .clean_first (clean_first),
        .busy        (busy),
        .gnt_valid   (gnt_valid),
        .gnt_index   (gnt_index),
        .gnt_dirty   (gnt_dirty)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mark(input int idx, input bit wr);
        @(negedge clk);
        mark_valid = 1'b1;
        mark_index = IW'(idx);
        mark_write = wr;
        @(negedge clk);
        mark_valid = 1'b0;
        mark_write = 1'b0;
    endtask

    // strobe_at: scan cycle in which a read mark to strobe_idx is driven (0 = none)
    task automatic request(input bit mode, input int exp_idx, input bit exp_dirty,
                           input int exp_scan, input int strobe_at, input int strobe_idx,
                           input string tag);
        int scan;
        @(negedge clk);
        req_valid   = 1'b1;
        clean_first = mode;
        @(negedge clk);
        req_valid = 1'b0;
        scan = 0;
        while (!gnt_valid && scan < 200) begin
            scan++;
            if (scan == strobe_at) begin
                mark_valid = 1'b1;
                mark_index = IW'(strobe_idx);
                mark_write = 1'b0;
            end else begin
                mark_valid = 1'b0;
            end
            @(negedge clk);
        end
        mark_valid = 1'b0;
        chk(gnt_valid == 1'b1, {tag, " grant seen"}, int'(gnt_valid), 1);
        chk(int'(gnt_index) == exp_idx, {tag, " victim index"}, int'(gnt_index), exp_idx);
        chk(gnt_dirty == exp_dirty, {tag, " victim dirty"}, int'(gnt_dirty), int'(exp_dirty));
        chk(scan == exp_scan, {tag, " frames examined"}, scan, exp_scan);
        @(negedge clk);
        chk(!gnt_valid && !busy, {tag, " R7 grant one cycle"}, int'({gnt_valid, busy}), 0);
    endtask

    task automatic t_reset();
        chk(!busy, "R10 busy low after reset", int'(busy), 0);
        chk(!gnt_valid, "R10 no grant after reset", int'(gnt_valid), 0);
        request(1'b0, 0, 1'b0, 1, 0, 0, "R10 R3 hand at 0, flags clear");
    endtask

    task automatic t_basic_sweep();
        mark(1, 1'b0); mark(2, 1'b0); mark(3, 1'b0);
        request(1'b0, 4, 1'b0, 4, 0, 0, "R1 R2 skip referenced");
    endtask

    task automatic t_full_wrap();
        for (int i = 0; i < N; i++) mark(i, 1'b0);
        request(1'b0, 5, 1'b0, 9, 0, 0, "R6 R5 all referenced");
        mark(6, 1'b0); mark(7, 1'b0);
        request(1'b0, 0, 1'b0, 3, 0, 0, "R3 wrap to frame 0");
    endtask

    task automatic t_dirty();
        mark(1, 1'b1);
        request(1'b0, 2, 1'b0, 2, 0, 0, "R1 write mark");
        for (int i = 3; i < N; i++) mark(i, 1'b0);
        mark(0, 1'b0);
        request(1'b0, 1, 1'b1, 7, 0, 0, "R8 dirty victim");
        for (int i = 2; i < N; i++) mark(i, 1'b0);
        mark(0, 1'b0);
        request(1'b1, 1, 1'b0, 8, 0, 0, "R8 R4 dirty cleared on grant");
    endtask

    task automatic t_clean_pref();
        mark(2, 1'b1); mark(3, 1'b1);
        request(1'b0, 1, 1'b0, 8, 0, 0, "R2 clear whole lap");
        request(1'b1, 4, 1'b0, 3, 0, 0, "R4 clean preferred");
        mark(5, 1'b0); mark(6, 1'b0); mark(7, 1'b0);
        mark(0, 1'b0); mark(1, 1'b0); mark(4, 1'b0);
        request(1'b1, 2, 1'b1, 14, 0, 0, "R4 R6 fallback to sweep");
    endtask

    task automatic t_collision();
        mark(3, 1'b0); mark(4, 1'b0); mark(5, 1'b0);
        request(1'b0, 6, 1'b0, 4, 2, 4, "R9 mark during clear");
        mark(7, 1'b0); mark(0, 1'b0); mark(1, 1'b0); mark(2, 1'b0); mark(3, 1'b0);
        request(1'b0, 5, 1'b0, 7, 0, 0, "R9 flag survived clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_sweep();
        t_full_wrap();
        t_dirty();
        t_clean_pref();
        t_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule